// File: doc/BRIEF.md
# Filtered Performance Counter Bank

This block holds a set of programmable hardware event counters for a processor's performance-monitoring unit. The counters occupy indices starting at 3 and run up to a count fixed by a parameter. Each counter has an event-select register. That register carries five mode-inhibit bits and a sticky overflow flag. Every cycle the block receives one event pulse per counter index, the current privilege level and a virtualization flag. A counter advances by one only if its global inhibit bit is clear and no mode-inhibit bit matches the current mode.

A counter holding all ones wraps to zero on its next counted event. If the counter's overflow flag was clear at that moment, the block sets the flag and raises a shared counter-overflow interrupt request. If the flag was already set, the wrap raises nothing new. Software can write each counter and each event-select register as one full 64-bit word or as separate 32-bit low and high halves. In the 32-bit view the mode-inhibit bits and the overflow flag sit in the high half.

Top module: `pmu_ctr_bank`

## Requirements
- R1: After reset every counter and every event-select register reads zero, and `lcof_irq` is low.
- R2: Only indices FIRST_IDX (3) to FIRST_IDX+NUM_CTRS-1 are implemented. Event pulses and writes aimed at any other index have no effect, and reading any other index returns zero.
- R3: While bit i of `cnt_inhibit` is set, counter i does not advance.
- R4: Event-select bits 62, 61, 60, 59 and 58 block counting in M-mode, S-mode with `virt_on` low, U-mode with `virt_on` low, S-mode with `virt_on` high and U-mode with `virt_on` high, respectively. The `priv` encoding is 3 = M, 1 = S, 0 = U. M-mode ignores `virt_on`.
- R5: Each counted event adds exactly one. When the low 32-bit half is all ones, the carry reaches the high half.
- R6: A counter holding all ones becomes zero after one counted event.
- R7: On that wrap, if bit 63 of the event-select register (the overflow flag) is clear, the flag is set and `lcof_irq` is raised on the following cycle.
- R8: A wrap that occurs while the overflow flag is already set leaves `lcof_irq` low.
- R9: `lcof_irq` stays high until `irq_clr` is pulsed. The overflow flag stays set until software writes the event-select high half.
- R10: If a counter write and a counted event arrive in the same cycle, the written value is stored and the event is dropped.
- R11: The `wr_kind` codes are 0 = counter low half, 1 = counter high half, 2 = whole counter, 3 = select low half, 4 = select high half, 5 = whole select. A half write takes its data from `wr_data[31:0]` and leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | MAX_CTRS | One event pulse per counter index |
| cnt_inhibit | input | MAX_CTRS | Global per-index count inhibit |
| priv | input | 2 | Current privilege level (3 M, 1 S, 0 U) |
| virt_on | input | 1 | Virtualization active |
| wr_en | input | 1 | Software write strobe |
| wr_kind | input | 3 | Write target and width (see R11) |
| wr_idx | input | IDX_W | Counter index being written |
| wr_data | input | CNT_W | Write data |
| irq_clr | input | 1 | Clears the overflow interrupt request |
| rd_idx | input | IDX_W | Counter index being read |
| rd_cnt | output | CNT_W | Counter value at `rd_idx` |
| rd_evt | output | CNT_W | Event-select value at `rd_idx` |
| lcof_irq | output | 1 | Shared counter-overflow interrupt request |

## Verification
The bench runs a table that pairs every privilege and virtualization combination with single inhibit bits. A filter that reads the wrong bit, or does not let M-mode ignore the virtualization flag, would count where it should hold or hold where it should count. Directed cases cover the following:
- the carry from the low half into the high half, which a design that splits the halves badly would lose;
- the full wrap while the overflow flag is already set, where a non-sticky design would raise a second interrupt;
- a write and an event landing on the same cycle, where the wrong priority leaves the written value plus one;
- pulses and writes on indices outside the implemented range, which a loose decoder would let change state.

// File: rtl/pmu_ctr_pkg.sv
package pmu_ctr_pkg;
  typedef enum logic [2:0] {
    WK_CNT_LO  = 3'd0,
    WK_CNT_HI  = 3'd1,
    WK_CNT_ALL = 3'd2,
    WK_EVT_LO  = 3'd3,
    WK_EVT_HI  = 3'd4,
    WK_EVT_ALL = 3'd5
  } wr_kind_e;

  // privilege encodings
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // number of mode-inhibit bits, packed {M, S, U, VS, VU} below the flag
  localparam int N_INH = 5;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/pmu_mode_filter.sv
module pmu_mode_filter
  import pmu_ctr_pkg::*;
(
  input  logic [N_INH-1:0] inh_bits,   // {M, S, U, VS, VU}
  input  logic [1:0]       priv,
  input  logic             virt_on,
  output logic             blocked
);
  logic in_m, in_s, in_u;

  always_comb begin
    in_m = (priv == PRV_M);
    in_s = (priv == PRV_S);
    in_u = (priv == PRV_U);
    blocked = (in_m && inh_bits[4])
            | (in_s && !virt_on && inh_bits[3])
            | (in_u && !virt_on && inh_bits[2])
            | (in_s &&  virt_on && inh_bits[1])
            | (in_u &&  virt_on && inh_bits[0]);
  end
endmodule

// File: rtl/pmu_ctr_slot.sv
module pmu_ctr_slot
  import pmu_ctr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             glb_inh_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             cnt_we_lo,
  input  logic             cnt_we_hi,
  input  logic             evt_we_lo,
  input  logic             evt_we_hi,
  input  logic [CNT_W/2-1:0] wd_lo,
  input  logic [CNT_W/2-1:0] wd_hi,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] evt_o,
  output logic             ovf_req_o
);
  localparam int HALF   = CNT_W / 2;
  localparam int OF_POS = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] evt_q, evt_d;
  logic [HALF-1:0]  lo_q, hi_q;
  logic             mode_blk;
  logic             cnt_wr, inc, cnt_en, evt_en, ovf_req;

  assign lo_q = cnt_q[HALF-1:0];
  assign hi_q = cnt_q[CNT_W-1:HALF];

  pmu_mode_filter u_filter (
    .inh_bits (evt_q[OF_POS-1 -: N_INH]),
    .priv     (priv_i),
    .virt_on  (virt_i),
    .blocked  (mode_blk)
  );

  always_comb begin
    cnt_wr  = cnt_we_lo | cnt_we_hi;
    inc     = evt_i & ~glb_inh_i & ~mode_blk;
    cnt_d   = cnt_q;
    evt_d   = evt_q;
    ovf_req = 1'b0;
    if (cnt_wr) begin
      if (cnt_we_lo) cnt_d[HALF-1:0]     = wd_lo;
      if (cnt_we_hi) cnt_d[CNT_W-1:HALF] = wd_hi;
    end else if (inc) begin
      cnt_d[HALF-1:0]     = lo_q + 1'b1;
      cnt_d[CNT_W-1:HALF] = (&lo_q) ? hi_q + 1'b1 : hi_q;
      ovf_req             = (&lo_q) & (&hi_q) & ~evt_q[OF_POS];
    end
    if (ovf_req) evt_d[OF_POS] = 1'b1;
    if (evt_we_lo) evt_d[HALF-1:0]     = wd_lo;
    if (evt_we_hi) evt_d[CNT_W-1:HALF] = wd_hi;
    cnt_en = cnt_wr | inc;
    evt_en = evt_we_lo | evt_we_hi | ovf_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (evt_en) evt_q <= evt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign evt_o     = evt_q;
  assign ovf_req_o = ovf_req;

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !glb_inh_i && !mode_blk && !cnt_wr && (cnt_o == '1)) |=> (cnt_o == '0));

  // R7
  of_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !glb_inh_i && !mode_blk && !cnt_wr && (cnt_o == '1) && !evt_we_hi)
    |=> evt_o[OF_POS]);

  // R3
  glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_inh_i && !cnt_wr) |=> $stable(cnt_o));

  // R9
  of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o[OF_POS] && !evt_we_hi) |=> evt_o[OF_POS]);

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we_lo && cnt_we_hi) |=> (cnt_o == $past({wd_hi, wd_lo})));
endmodule

// File: rtl/pmu_ctr_bank.sv
module pmu_ctr_bank
  import pmu_ctr_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int MAX_CTRS = 32,
  parameter int CNT_W    = 64,
  parameter int IDX_W    = $clog2(MAX_CTRS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_CTRS-1:0] evt_pulse,
  input  logic [MAX_CTRS-1:0] cnt_inhibit,
  input  logic [1:0]          priv,
  input  logic                virt_on,
  input  logic                wr_en,
  input  logic [2:0]          wr_kind,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic                irq_clr,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [CNT_W-1:0]    rd_evt,
  output logic                lcof_irq
);
  localparam int HALF      = CNT_W / 2;
  localparam int FIRST_IDX = 3;
  localparam logic [MAX_CTRS-1:0] ONE_HOT0 = {{(MAX_CTRS-1){1'b0}}, 1'b1};
  localparam logic [MAX_CTRS-1:0] AVAIL =
    ((ONE_HOT0 << NUM_CTRS) - ONE_HOT0) << FIRST_IDX;

  if (NUM_CTRS < 1 || NUM_CTRS > MAX_CTRS - FIRST_IDX) begin : g_bad_cfg
    $error("pmu_ctr_bank: NUM_CTRS out of range");
  end

  logic rst_n_s;
  pmu_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  wr_kind_e wk;
  assign wk = wr_kind_e'(wr_kind);

  logic [HALF-1:0] wd_lo, wd_hi;
  logic k_cnt_lo, k_cnt_hi, k_evt_lo, k_evt_hi;

  always_comb begin
    k_cnt_lo = (wk == WK_CNT_LO) || (wk == WK_CNT_ALL);
    k_cnt_hi = (wk == WK_CNT_HI) || (wk == WK_CNT_ALL);
    k_evt_lo = (wk == WK_EVT_LO) || (wk == WK_EVT_ALL);
    k_evt_hi = (wk == WK_EVT_HI) || (wk == WK_EVT_ALL);
    wd_lo    = wr_data[HALF-1:0];
    wd_hi    = ((wk == WK_CNT_ALL) || (wk == WK_EVT_ALL)) ?
               wr_data[CNT_W-1:HALF] : wr_data[HALF-1:0];
  end

  logic [CNT_W-1:0]    cnt_v [NUM_CTRS];
  logic [CNT_W-1:0]    evt_v [NUM_CTRS];
  logic [NUM_CTRS-1:0] ovf_v;

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_slot
    localparam logic [MAX_CTRS-1:0] SEL = ONE_HOT0 << (FIRST_IDX + i);
    logic s_evt, s_inh, s_wr;
    assign s_evt = |(evt_pulse & AVAIL & SEL);
    assign s_inh = |(cnt_inhibit & SEL);
    assign s_wr  = wr_en && (wr_idx == IDX_W'(FIRST_IDX + i));

    pmu_ctr_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .evt_i     (s_evt),
      .glb_inh_i (s_inh),
      .priv_i    (priv),
      .virt_i    (virt_on),
      .cnt_we_lo (s_wr && k_cnt_lo),
      .cnt_we_hi (s_wr && k_cnt_hi),
      .evt_we_lo (s_wr && k_evt_lo),
      .evt_we_hi (s_wr && k_evt_hi),
      .wd_lo     (wd_lo),
      .wd_hi     (wd_hi),
      .cnt_o     (cnt_v[i]),
      .evt_o     (evt_v[i]),
      .ovf_req_o (ovf_v[i])
    );
  end

  always_comb begin
    rd_cnt = '0;
    rd_evt = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (AVAIL[rd_idx] && (rd_idx == IDX_W'(FIRST_IDX + i))) begin
        rd_cnt = cnt_v[i];
        rd_evt = evt_v[i];
      end
    end
  end

  logic irq_q, irq_d;
  always_comb begin
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (|ovf_v)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign lcof_irq = irq_q;

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lcof_irq && !irq_clr) |=> lcof_irq);

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|ovf_v) |=> lcof_irq);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!lcof_irq && (ovf_v == '0)) |=> !lcof_irq);
endmodule

// File: tb/pmu_ctr_bank_bench.sv
`timescale 1ns/1ps
module pmu_ctr_bank_bench;
  localparam int NUM_CTRS = 4;
  localparam int MAX_CTRS = 32;
  localparam int CNT_W    = 64;
  localparam int IDX_W    = 5;

  logic                clk;
  logic                rst_n;
  logic [MAX_CTRS-1:0] evt_pulse;
  logic [MAX_CTRS-1:0] cnt_inhibit;
  logic [1:0]          priv;
  logic                virt_on;
  logic                wr_en;
  logic [2:0]          wr_kind;
  logic [IDX_W-1:0]    wr_idx;
  logic [CNT_W-1:0]    wr_data;
  logic                irq_clr;
  logic [IDX_W-1:0]    rd_idx;
  logic [CNT_W-1:0]    rd_cnt;
  logic [CNT_W-1:0]    rd_evt;
  logic                lcof_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pmu_ctr_bank #(.NUM_CTRS(NUM_CTRS), .MAX_CTRS(MAX_CTRS), .CNT_W(CNT_W)) u_pmu_ctr_bank (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cnt_inhibit(cnt_inhibit),
    .priv(priv), .virt_on(virt_on), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_idx(wr_idx), .wr_data(wr_data), .irq_clr(irq_clr), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .rd_evt(rd_evt), .lcof_irq(lcof_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {priv[1:0], virt, inh{M,S,U,VS,VU}, expect_count}
  localparam logic [8:0] VEC [11] = '{
    {2'd3, 1'b0, 5'b10000, 1'b0},
    {2'd3, 1'b0, 5'b01111, 1'b1},
    {2'd1, 1'b0, 5'b01000, 1'b0},
    {2'd1, 1'b0, 5'b00010, 1'b1},
    {2'd1, 1'b1, 5'b00010, 1'b0},
    {2'd1, 1'b1, 5'b01000, 1'b1},
    {2'd0, 1'b0, 5'b00100, 1'b0},
    {2'd0, 1'b0, 5'b00001, 1'b1},
    {2'd0, 1'b1, 5'b00001, 1'b0},
    {2'd0, 1'b1, 5'b00100, 1'b1},
    {2'd3, 1'b1, 5'b10000, 1'b0}
  };

  task automatic chk(input string req, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic swr(input logic [2:0] kind, input logic [IDX_W-1:0] idx, input logic [CNT_W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [MAX_CTRS-1:0] bits);
    @(negedge clk);
    evt_pulse = bits;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [IDX_W-1:0] idx);
    rd_idx = idx;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_pulse = '0; cnt_inhibit = '0; priv = 2'd3; virt_on = 1'b0;
    wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0; irq_clr = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 3; i < 7; i++) begin
      rd(IDX_W'(i));
      chk("R1 cnt", rd_cnt, '0);
      chk("R1 evt", rd_evt, '0);
    end
    chk("R1 irq", {63'd0, lcof_irq}, 64'd0);

    // R4 mode filter table on counter 3
    for (int v = 0; v < 11; v++) begin
      swr(3'd4, 5'd3, {32'd0, 1'b0, VEC[v][5:1], 26'd0});
      swr(3'd2, 5'd3, 64'd0);
      @(negedge clk);
      priv = VEC[v][8:7]; virt_on = VEC[v][6];
      evt_pulse = 32'h8;
      @(negedge clk);
      evt_pulse = '0;
      rd(5'd3);
      chk($sformatf("R4 vec%0d", v), rd_cnt, {63'd0, VEC[v][0]});
    end
    priv = 2'd3; virt_on = 1'b0;
    swr(3'd4, 5'd3, 64'd0);

    // R5 three events
    pulse(32'h10); pulse(32'h10); pulse(32'h10);
    rd(5'd4); chk("R5 count3", rd_cnt, 64'd3);

    // R5 carry into high half
    swr(3'd0, 5'd5, 64'hFFFF_FFFF);
    pulse(32'h20);
    rd(5'd5); chk("R5 carry", rd_cnt, 64'h1_0000_0000);

    // R6 R7 wrap with flag clear
    swr(3'd2, 5'd5, '1);
    pulse(32'h20);
    rd(5'd5);
    chk("R6 wrap", rd_cnt, 64'd0);
    chk("R7 flag", {63'd0, rd_evt[63]}, 64'd1);
    chk("R7 irq", {63'd0, lcof_irq}, 64'd1);

    // R9 irq sticky, then cleared
    repeat (3) @(negedge clk);
    chk("R9 irq held", {63'd0, lcof_irq}, 64'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R9 irq clr", {63'd0, lcof_irq}, 64'd0);

    // R8 wrap with flag set
    swr(3'd2, 5'd5, '1);
    pulse(32'h20);
    rd(5'd5);
    chk("R8 wrap cnt", rd_cnt, 64'd0);
    chk("R8 no irq", {63'd0, lcof_irq}, 64'd0);
    chk("R9 flag kept", {63'd0, rd_evt[63]}, 64'd1);

    // R9 flag cleared by high-half write, next wrap raises again
    swr(3'd4, 5'd5, 64'd0);
    rd(5'd5); chk("R9 flag clr", rd_evt, 64'd0);
    swr(3'd2, 5'd5, '1);
    pulse(32'h20);
    chk("R7 irq again", {63'd0, lcof_irq}, 64'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

    // R3 global inhibit
    cnt_inhibit = 32'h10;
    pulse(32'h10);
    rd(5'd4); chk("R3 inhibit", rd_cnt, 64'd3);
    cnt_inhibit = '0;

    // R2 out-of-range indices
    pulse(32'h87);
    for (int i = 3; i < 7; i++) begin
      rd(IDX_W'(i));
      chk($sformatf("R2 idx%0d", i), rd_cnt, (i == 4) ? 64'd3 : 64'd0);
    end
    swr(3'd2, 5'd7, 64'd55);
    swr(3'd2, 5'd2, 64'd55);
    rd(5'd7); chk("R2 rd7", rd_cnt, 64'd0);
    rd(5'd2); chk("R2 rd2", rd_cnt, 64'd0);
    rd(5'd6); chk("R2 idx6 untouched", rd_cnt, 64'd0);

    // R10 write beats event
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 3'd2; wr_idx = 5'd6; wr_data = 64'd100; evt_pulse = 32'h40;
    @(negedge clk);
    wr_en = 1'b0; evt_pulse = '0;
    rd(5'd6); chk("R10 prio", rd_cnt, 64'd100);

    // R11 half writes
    swr(3'd1, 5'd6, 64'd5);
    rd(5'd6); chk("R11 hi", rd_cnt, 64'h5_0000_0064);
    swr(3'd0, 5'd6, 64'h7);
    rd(5'd6); chk("R11 lo", rd_cnt, 64'h5_0000_0007);
    swr(3'd3, 5'd6, 64'h0000_0001_0000_0009);
    rd(5'd6); chk("R11 evt lo", rd_evt, 64'h9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule